// File: doc/BRIEF.md
# Reset Cause Status Register with Watchdog

This block keeps the processor status byte that tells firmware why the device last came out of reset and whether an interrupt is waiting. It records three reset causes as sticky flags: a power-on reset, a watchdog expiry and a USB bus reset event. It also holds three general control bits and shows two live status bits, the registered interrupt-pending indication and the CPU global interrupt enable. Firmware reads the byte through a simple 8-bit port. Writing a 0 to a cause flag clears it.

The block contains the watchdog timer. Firmware must pulse the clear strobe at least once every `WD_CYCLES` clock cycles. If the clear stays away for longer than that, the block emits a one-cycle watchdog reset pulse and loads the watchdog pattern into the status byte. That pattern keeps the power-on and bus-reset flags, so firmware can still tell that a power-on came first. The power-on reset input is the block's synchronous active-low reset.

Top module: `rcs_status_top`

## Requirements
- R1: When `por_n` is low at a rising edge, the next read returns 0x11, with bit 2 showing `gie`. Bit 4 is the power-on flag and bit 0 is a control bit that starts at 1. The watchdog pulse is low.
- R2: If `wd_clear` stays low for `WD_CYCLES`+1 consecutive edges after the last clear or reset, `wdog_rst` goes high for exactly one cycle and the count restarts from zero.
- R3: A `wd_clear` pulse resets the count to zero, including a pulse on the edge where expiry would occur. Clears spaced at most `WD_CYCLES` cycles apart never produce a pulse.
- R4: In the cycle `wdog_rst` is high, bit 6 (watchdog flag) is 1, bit 7 is 0, control bits 3 and 1 are 0, bit 0 is 1, and bits 5 and 4 keep their previous values.
- R5: A `bus_rst_evt` pulse sets bit 5 from the next cycle on. The bit stays set until firmware clears it.
- R6: Bit 7 shows `irq_pend` as sampled at the previous edge, and is forced to 0 by a watchdog load.
- R7: Bit 2 always shows the current `gie` level. Writes to bit 2 have no effect.
- R8: A write clears each of bits 4, 5 and 6 where the written bit is 0 and leaves it unchanged where the written bit is 1. The value written to bit 7 is ignored.
- R9: A write stores the written values of control bits 0, 1 and 3.
- R10: A bus-reset event wins over a same-cycle write of 0 to bit 5. A watchdog load discards a write made in the same cycle.
- R11: After a power-on reset followed by a watchdog expiry with no clear in between, the read returns 0x51 (with `gie` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| wd_clear | input | 1 | Watchdog clear strobe from firmware |
| bus_rst_evt | input | 1 | One-cycle USB bus reset event |
| irq_pend | input | 1 | An interrupt is recognised as pending |
| gie | input | 1 | CPU global interrupt enable state |
| reg_wr | input | 1 | Write strobe for the status byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current status byte |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
Two things can land on the same edge: the watchdog load, and a firmware write or bus-reset event. The bench tracks the watchdog count in its own model, waits for the exact expiry edge, and issues a write of 0x00 together with a bus event on that edge. The expected result is that the write is discarded and bit 5 is still set. A second collision puts a clear-by-zero write to bit 5 on the same edge as a bus event, and the bus event must win. A third puts a clear strobe on the expiry edge, and no pulse may follow.

// File: rtl/rcs_pkg.sv
// Shared constants for the reset cause status register.
// Assumes an 8-bit status byte with fixed flag positions.
package rcs_pkg;
    localparam int STAT_W     = 8;
    localparam int BIT_PWR    = 4;
    localparam int BIT_BUS    = 5;
    localparam int BIT_WDG    = 6;
    localparam int BIT_IRQ    = 7;
    localparam int BIT_GIE    = 2;
    // flags cleared by writing 0
    localparam logic [STAT_W-1:0] STICKY_MASK = 8'h70;
    // plain read/write control bits 3, 1, 0
    localparam logic [STAT_W-1:0] CTRL_MASK   = 8'h0B;
    // flags kept across a watchdog load
    localparam logic [STAT_W-1:0] WDG_KEEP    = 8'h30;
    localparam logic [STAT_W-1:0] PWRUP_VAL   = 8'h11;
    localparam logic [STAT_W-1:0] WDG_SET     = 8'h41;
endpackage

// File: rtl/rcs_wdog.sv
// Watchdog counter. It counts cycles since the last clear and raises a
// load strobe on the edge where the count sits at WD_CYCLES with no clear.
// Assumes por_n is a synchronous active-low reset.
module rcs_wdog #(
    parameter int WD_CYCLES = 1000
) (
    input  logic clk,
    input  logic por_n,
    input  logic wd_clear,
    output logic wd_load,
    output logic wd_pulse
);
    localparam int CNT_W = $clog2(WD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WD_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // expiry: the limit is reached and no clear arrives this cycle
    assign wd_load = (cnt_q == LIMIT) && !wd_clear;

    // count cycles and restart on a clear or an expiry
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt_q    <= '0;
            wd_pulse <= 1'b0;
        end else begin
            wd_pulse <= wd_load;
            if (wd_clear || wd_load)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q <= LIMIT);
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!por_n)
        wd_pulse |=> !wd_pulse);
    a_r3_clear_blocks: assert property (@(posedge clk) disable iff (!por_n)
        wd_clear |=> !wd_pulse);
endmodule

// File: rtl/rcs_flags.sv
// Status byte storage: sticky reset-cause flags, control bits and the
// registered interrupt-pending bit. Bit 2 is stored as 0 and filled in
// from gie on read. Assumes a synchronous active-low power-on reset.
module rcs_flags
    import rcs_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              wd_load,
    input  logic              bus_rst_evt,
    input  logic              irq_pend,
    input  logic              gie,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata
);
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] stat_d;

    // next value: watchdog load beats a write; set events beat clears
    always_comb begin
        if (wd_load) begin
            stat_d = (stat_q & WDG_KEEP) | WDG_SET;
        end else begin
            stat_d = stat_q;
            if (reg_wr)
                stat_d = (stat_q & ~(STICKY_MASK | CTRL_MASK))
                       | (stat_q & STICKY_MASK & reg_wdata)
                       | (reg_wdata & CTRL_MASK);
            stat_d[BIT_IRQ] = irq_pend;
        end
        stat_d[BIT_BUS] = stat_d[BIT_BUS] | bus_rst_evt;
        stat_d[BIT_GIE] = 1'b0;
    end

    // hold the status byte, loading the power-up pattern on reset
    always_ff @(posedge clk) begin
        if (!por_n)
            stat_q <= PWRUP_VAL;
        else
            stat_q <= stat_d;
    end

    // read path merges the live enable state
    assign reg_rdata = stat_q | (gie ? 8'h04 : 8'h00);

    a_r1_pwrup: assert property (@(posedge clk)
        !por_n |=> (stat_q == PWRUP_VAL));
    a_r4_wdg_flags: assert property (@(posedge clk) disable iff (!por_n)
        wd_load |=> (stat_q[BIT_WDG] && !stat_q[BIT_IRQ]));
    a_r4_keep_pwr: assert property (@(posedge clk) disable iff (!por_n)
        wd_load |=> (stat_q[BIT_PWR] == $past(stat_q[BIT_PWR])));
    a_r5_bus_sets: assert property (@(posedge clk) disable iff (!por_n)
        bus_rst_evt |=> stat_q[BIT_BUS]);
    a_r8_clear_pwr: assert property (@(posedge clk) disable iff (!por_n)
        (reg_wr && !wd_load && !reg_wdata[BIT_PWR]) |=> !stat_q[BIT_PWR]);
    a_r7_gie_live: assert property (@(posedge clk)
        reg_rdata[BIT_GIE] == gie);
endmodule

// File: rtl/rcs_status_top.sv
// Reset cause status register top: joins the watchdog timer and the
// status byte. The watchdog load and its output pulse share an edge.
// Assumes por_n is the synchronous active-low power-on reset.
module rcs_status_top #(
    parameter int WD_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       wd_clear,
    input  logic       bus_rst_evt,
    input  logic       irq_pend,
    input  logic       gie,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       wdog_rst
);
    logic wd_load;

    rcs_wdog #(.WD_CYCLES(WD_CYCLES)) u_wdog (
        .clk      (clk),
        .por_n    (por_n),
        .wd_clear (wd_clear),
        .wd_load  (wd_load),
        .wd_pulse (wdog_rst)
    );

    rcs_flags u_flags (
        .clk         (clk),
        .por_n       (por_n),
        .wd_load     (wd_load),
        .bus_rst_evt (bus_rst_evt),
        .irq_pend    (irq_pend),
        .gie         (gie),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata)
    );

    a_r4_pulse_flag: assert property (@(posedge clk) disable iff (!por_n)
        wdog_rst |-> (reg_rdata[6] && !reg_rdata[7]));
endmodule

// File: tb/test_rcs_status_top.sv
// Scoreboard bench: the driver updates a spec model and queues expected
// bytes; the monitor compares them at the falling edge.
module test_rcs_status_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDC = 20;

    logic clk = 1'b0;
    logic por_n = 1'b0, wd_clear = 1'b0, bus_rst_evt = 1'b0, irq_pend = 1'b0;
    logic gie = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic wdog_rst;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       wd;
    } exp_t;
    exp_t sb[$];

    // spec model state
    logic m_pwr = 1'b1, m_bus = 1'b0, m_wdg = 1'b0, m_irq = 1'b0;
    logic [2:0] m_ctl = 3'b001;
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcs_status_top #(.WD_CYCLES(WDC)) i_rcs_status_top (
        .clk(clk), .por_n(por_n), .wd_clear(wd_clear),
        .bus_rst_evt(bus_rst_evt), .irq_pend(irq_pend), .gie(gie),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wdog_rst(wdog_rst));

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // one cycle: drive, clock, update model, queue expectation
    task automatic step(input logic p, input logic w, input logic [7:0] d,
                        input logic c, input logic b, input logic i,
                        input logic g, input string tag);
        exp_t e;
        logic fire;
        por_n = p; reg_wr = w; reg_wdata = d; wd_clear = c;
        bus_rst_evt = b; irq_pend = i; gie = g;
        @(posedge clk);
        #1;
        fire = 1'b0;
        if (!p) begin
            m_pwr = 1; m_bus = 0; m_wdg = 0; m_irq = 0; m_ctl = 3'b001; m_cnt = 0;
        end else begin
            fire = (m_cnt == WDC) && !c;
            m_cnt = (c || fire) ? 0 : m_cnt + 1;
            if (fire) begin
                m_wdg = 1; m_irq = 0; m_ctl = 3'b001;
            end else begin
                if (w) begin
                    m_pwr &= d[4]; m_bus &= d[5]; m_wdg &= d[6];
                    m_ctl = {d[3], d[1], d[0]};
                end
                m_irq = i;
            end
            m_bus |= b;
        end
        e.tag = tag;
        e.rd  = {m_irq, m_wdg, m_bus, m_pwr, m_ctl[2], g, m_ctl[1], m_ctl[0]};
        e.wd  = fire;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic idle(input logic c, input string tag);
        step(1, 0, 8'h00, c, 0, 0, 0, tag);
    endtask

    // monitor: compare outputs with the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (reg_rdata !== e.rd || wdog_rst !== e.wd) begin
                    fails++;
                    $display("FAIL %s rdata=%h exp=%h wdog=%b exp=%b",
                             e.tag, reg_rdata, e.rd, wdog_rst, e.wd);
                end
            end
        end
    end

    // watchdog for a hung run
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL timeout");
        summary();
    end

    initial begin
        @(negedge clk); #1;
        step(0, 0, 8'h00, 0, 0, 0, 0, "R1 reset");
        step(0, 0, 8'h00, 0, 0, 0, 1, "R1 reset gie");
        // R3: periodic clears hold the watchdog off
        for (int k = 0; k < 60; k++) idle((k % WDC) == WDC - 1, "R3 spaced clear");
        // R5 bus event, R6 irq mirror, R7 gie
        step(1, 0, 8'h00, 1, 1, 0, 0, "R5 bus set");
        step(1, 0, 8'h00, 1, 0, 1, 1, "R6 irq high R7");
        step(1, 0, 8'h00, 1, 0, 0, 0, "R6 irq low");
        // R8 write 1s keep, bit7 ignored, R9 ctrl bits
        step(1, 1, 8'hFF, 1, 0, 0, 0, "R8 keep ones R9");
        step(1, 1, 8'h8A, 1, 0, 1, 0, "R8 bit7 ignored R9");
        step(1, 1, 8'h20, 1, 0, 1, 1, "R8 clear pwr R7");
        step(1, 1, 8'h00, 1, 1, 0, 0, "R10 bus beats clear");
        step(1, 1, 8'h00, 1, 0, 0, 0, "R8 clear bus");
        step(1, 1, 8'h70, 1, 1, 0, 0, "R5 set again");
        // R2 and R4: expiry with bus flag set, irq pending
        while (m_cnt != WDC) step(1, 0, 8'h00, 0, 0, 1, 0, "R2 run");
        step(1, 0, 8'h00, 0, 0, 1, 0, "R2 R4 expire");
        step(1, 0, 8'h00, 0, 0, 0, 0, "R2 single pulse");
        // R10: expiry together with a write and a bus event
        while (m_cnt != WDC) idle(0, "R2 run2");
        step(1, 1, 8'h00, 0, 1, 0, 0, "R10 load beats write");
        // R3: clear exactly on the expiry edge
        while (m_cnt != WDC) idle(0, "R3 run");
        idle(1, "R3 clear at limit");
        for (int k = 0; k <= WDC; k++) idle(0, "R2 after late clear");
        // R11: power-on then expiry without clear
        step(0, 0, 8'h00, 0, 0, 0, 0, "R1 reset again");
        for (int k = 0; k <= WDC; k++) idle(0, "R11 por then wdog");
        if (m_bus || m_irq || !m_pwr || !m_wdg) begin
            fails++;
            $display("FAIL R11 model state rdata=%h exp=51", reg_rdata);
        end
        idle(1, "R11 hold 0x51");
        while (sb.size() > 0) @(negedge clk);
        summary();
    end
endmodule